// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns a 64-bit register operand into an IEEE binary floating-point value. A 2-bit type code says how the operand is read: as a signed or unsigned 32-bit word taken from its low half, or as a signed or unsigned 64-bit integer. A single-precision select chooses the destination. With it low the result is binary64. With it high the value is rounded to binary32 precision and range, then delivered widened into binary64 layout.

The operand is reduced to a sign and a magnitude. One leading-zero count and left shift normalise the magnitude, and that shifted value feeds two rounding lanes, one per destination precision. A 2-bit mode input picks the rounding direction. A 32-bit source going to double is always exact: on that path rounding is bypassed and no status is reported. Every other path asks for a status update and reports inexact results. The unit also gives a 5-bit class code for the result and, when the record bit is set, a 4-bit condition field taken from it.

All outputs are registered once. A result is due one clock edge after its operands are presented.

Top module: `i2f_convert`

## Requirements
- R1: An operand whose selected integer is zero gives the result 0x0000000000000000 (positive zero), class 5'b00010 and inexact 0.
- R2: Type code 0 reads opnd_i[31:0] as signed, 1 reads it as unsigned, 2 reads opnd_i[63:0] as signed and 3 reads it as unsigned. For codes 0 and 1, opnd_i[63:32] has no effect on any output.
- R3: When ityp_i[1] is 0 and sgl_i is 0, the result is the exact binary64 value, with flag_upd_o, inexact_o and exc_sum_o all 0.
- R4: In every other case flag_upd_o is 1, and the significand is rounded by rmode_i: 0 nearest with ties to even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R5: With sgl_i 1, the value is rounded to a 24-bit significand. It is returned as binary64 with the same value, so res_o[28:0] is zero.
- R6: class_o is 5'b00100 for a positive normal result, 5'b01000 for a negative normal result and 5'b00010 for positive zero. It is taken from the binary32 value when sgl_i is 1 and from the binary64 value otherwise.
- R7: When the rounded value differs from the integer, inexact_o and exc_sum_o are both 1. Otherwise both are 0.
- R8: cond_o equals class_o[4:1] when rec_i is 1, and 4'b0000 when rec_i is 0.
- R9: A rounding carry out of the significand raises the exponent by one (2^64-1 to nearest gives 0x43F0000000000000). The signed 64-bit minimum converts exactly to 0xC3E0000000000000.
- R10: Outputs are registered and change one rising clock edge after the inputs. While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_i | input | 64 | Integer operand |
| ityp_i | input | 2 | Source type: 0 s32, 1 u32, 2 s64, 3 u64 |
| sgl_i | input | 1 | 1 selects a single-precision result |
| rmode_i | input | 2 | Rounding mode |
| rec_i | input | 1 | Record bit, enables the condition field |
| res_o | output | 64 | Result in binary64 layout |
| inexact_o | output | 1 | Rounded result was inexact |
| flag_upd_o | output | 1 | Status flags are to be updated |
| exc_sum_o | output | 1 | Summary exception indication |
| class_o | output | 5 | Result class code |
| cond_o | output | 4 | Condition field |

## Verification
Every output is due exactly one rising edge after its operands. The bench applies each vector on a falling edge and samples all outputs on the next falling edge, so exactly one capturing edge lies between stimulus and check. A separate test drives new operands and reads the outputs again before the next rising edge, to confirm they still hold the previous result. Reset is checked asynchronously, a fraction of a nanosecond after rst_n falls, with no clock edge in between. The checker compares each output against the inputs seen one edge earlier, using $past of depth one.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned DP_FRAC  = 52;
  localparam int unsigned DP_EXPW  = 11;
  localparam int unsigned DP_BIAS  = 1023;
  localparam int unsigned SP_FRAC  = 23;
  localparam int unsigned SP_EXPW  = 8;
  localparam int unsigned SP_BIAS  = 127;
  localparam int unsigned PAD_W    = DP_FRAC - SP_FRAC;
  localparam int unsigned CLS_W    = 5;
  localparam int unsigned CND_W    = 4;

  typedef enum logic [1:0] {
    ITYP_S32 = 2'd0,
    ITYP_U32 = 2'd1,
    ITYP_S64 = 2'd2,
    ITYP_U64 = 2'd3
  } ityp_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_PINF = 2'd2,
    RM_MINF = 2'd3
  } rmode_e;

  localparam logic [CLS_W-1:0] CLS_POS_NORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NEG_NORM = 5'b01000;
  localparam logic [CLS_W-1:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_NEG_ZERO = 5'b10010;
  localparam logic [CLS_W-1:0] CLS_POS_INF  = 5'b00101;
  localparam logic [CLS_W-1:0] CLS_NEG_INF  = 5'b01001;
endpackage

// File: rtl/i2f_src_select.sv
// Reduces the operand to sign and unsigned magnitude per source type (R2).
module i2f_src_select
  import i2f_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] opnd,
  input  ityp_e        ityp,
  output logic         sign,
  output logic [W-1:0] mag,
  output logic         is_zero
);
  localparam int unsigned HALF = W / 2;

  logic [HALF-1:0] lo_word;
  logic [HALF-1:0] lo_neg;
  logic [W-1:0]    full_neg;

  assign lo_word  = opnd[HALF-1:0];
  assign lo_neg   = ~lo_word + HALF'(1);
  assign full_neg = ~opnd + W'(1);

  always_comb begin
    unique case (ityp)
      ITYP_S32: begin
        sign = lo_word[HALF-1];
        mag  = {{HALF{1'b0}}, (sign ? lo_neg : lo_word)};
      end
      ITYP_U32: begin
        sign = 1'b0;
        mag  = {{HALF{1'b0}}, lo_word};
      end
      ITYP_S64: begin
        sign = opnd[W-1];
        mag  = sign ? full_neg : opnd;
      end
      default: begin
        sign = 1'b0;
        mag  = opnd;
      end
    endcase
  end

  assign is_zero = (mag == '0);
endmodule

// File: rtl/i2f_normalize.sv
// Leading-zero count and left shift so the top set bit lands at W-1.
module i2f_normalize #(
  parameter int unsigned W   = 64,
  parameter int unsigned LZW = $clog2(W)
) (
  input  logic [W-1:0]   mag,
  output logic [W-1:0]   norm,
  output logic [LZW-1:0] lz
);
  always_comb begin
    logic found;
    found = 1'b0;
    lz    = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && mag[i]) begin
        lz    = LZW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign norm = mag << lz;
endmodule

// File: rtl/i2f_round.sv
// Rounds the normalised magnitude to FRAC+1 significant bits (R4, R9).
module i2f_round
  import i2f_pkg::*;
#(
  parameter int unsigned W    = 64,
  parameter int unsigned FRAC = 52,
  parameter int unsigned EXPW = 11,
  parameter int unsigned BIAS = 1023,
  parameter int unsigned LZW  = $clog2(W)
) (
  input  logic [W-1:0]    norm,
  input  logic [LZW-1:0]  lz,
  input  logic            sign,
  input  rmode_e          rmode,
  input  logic            rnd_en,
  output logic [EXPW-1:0] exp_field,
  output logic [FRAC-1:0] frac,
  output logic            inexact
);
  localparam int unsigned KEEP = FRAC + 1;
  localparam int unsigned GPOS = W - 1 - KEEP;
  localparam int unsigned UEW  = LZW + 1;

  logic [KEEP-1:0] kept;
  logic            guard;
  logic            sticky;
  logic            lost;
  logic            inc;
  logic [KEEP:0]   sum;
  logic            carry;
  logic [UEW-1:0]  uexp;

  assign kept   = norm[W-1 -: KEEP];
  assign guard  = norm[GPOS];
  assign sticky = |norm[GPOS-1:0];
  assign lost   = guard | sticky;

  always_comb begin
    inc = 1'b0;
    if (rnd_en) begin
      unique case (rmode)
        RM_NEAR: inc = guard & (sticky | kept[0]);
        RM_ZERO: inc = 1'b0;
        RM_PINF: inc = lost & ~sign;
        default: inc = lost & sign;
      endcase
    end
  end

  assign sum       = {1'b0, kept} + {{KEEP{1'b0}}, inc};
  assign carry     = sum[KEEP];
  assign frac      = carry ? '0 : sum[FRAC-1:0];
  assign uexp      = UEW'(W - 1) - UEW'(lz) + UEW'(carry);
  assign exp_field = EXPW'(BIAS) + EXPW'(uexp);
  assign inexact   = rnd_en & lost;
endmodule

// File: rtl/i2f_classify.sv
// Class code from sign and the exponent field of the chosen format (R6).
module i2f_classify
  import i2f_pkg::*;
(
  input  logic             sign,
  input  logic             is_zero,
  input  logic             is_inf,
  output logic [CLS_W-1:0] cls
);
  always_comb begin
    if (is_zero)     cls = sign ? CLS_NEG_ZERO : CLS_POS_ZERO;
    else if (is_inf) cls = sign ? CLS_NEG_INF  : CLS_POS_INF;
    else             cls = sign ? CLS_NEG_NORM : CLS_POS_NORM;
  end
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
  import i2f_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  opnd_i,
  input  logic [1:0]       ityp_i,
  input  logic             sgl_i,
  input  logic [1:0]       rmode_i,
  input  logic             rec_i,
  output logic [XLEN-1:0]  res_o,
  output logic             inexact_o,
  output logic             flag_upd_o,
  output logic             exc_sum_o,
  output logic [CLS_W-1:0] class_o,
  output logic [CND_W-1:0] cond_o
);
  localparam int unsigned LZW = $clog2(XLEN);

  logic              src_sign;
  logic [XLEN-1:0]   src_mag;
  logic              src_zero;
  logic [XLEN-1:0]   norm;
  logic [LZW-1:0]    lz;
  logic              exact_path;

  logic [DP_EXPW-1:0] dp_exp;
  logic [DP_FRAC-1:0] dp_frac;
  logic               dp_inx;
  logic [SP_EXPW-1:0] sp_exp;
  logic [SP_FRAC-1:0] sp_frac;
  logic               sp_inx;

  logic [DP_EXPW-1:0] sel_exp;
  logic [DP_FRAC-1:0] sel_frac;
  logic               sel_inf;
  logic [CLS_W-1:0]   cls_d;

  logic [XLEN-1:0]    res_d;
  logic               inexact_d;
  logic               upd_d;
  logic [CND_W-1:0]   cond_d;

  i2f_src_select #(.W(XLEN)) u_src (
    .opnd    (opnd_i),
    .ityp    (ityp_e'(ityp_i)),
    .sign    (src_sign),
    .mag     (src_mag),
    .is_zero (src_zero)
  );

  i2f_normalize #(.W(XLEN), .LZW(LZW)) u_norm (
    .mag  (src_mag),
    .norm (norm),
    .lz   (lz)
  );

  // 32-bit source to double never loses bits: rounding and status bypassed (R3)
  assign exact_path = ~ityp_i[1] & ~sgl_i;

  i2f_round #(
    .W(XLEN), .FRAC(DP_FRAC), .EXPW(DP_EXPW), .BIAS(DP_BIAS), .LZW(LZW)
  ) u_rnd_dp (
    .norm      (norm),
    .lz        (lz),
    .sign      (src_sign),
    .rmode     (rmode_e'(rmode_i)),
    .rnd_en    (~exact_path),
    .exp_field (dp_exp),
    .frac      (dp_frac),
    .inexact   (dp_inx)
  );

  i2f_round #(
    .W(XLEN), .FRAC(SP_FRAC), .EXPW(SP_EXPW), .BIAS(SP_BIAS), .LZW(LZW)
  ) u_rnd_sp (
    .norm      (norm),
    .lz        (lz),
    .sign      (src_sign),
    .rmode     (rmode_e'(rmode_i)),
    .rnd_en    (1'b1),
    .exp_field (sp_exp),
    .frac      (sp_frac),
    .inexact   (sp_inx)
  );

  // Single result widened: rebias exponent, left-align fraction (R5)
  always_comb begin
    if (sgl_i) begin
      sel_exp  = DP_EXPW'(sp_exp) + DP_EXPW'(DP_BIAS - SP_BIAS);
      sel_frac = {sp_frac, {PAD_W{1'b0}}};
      sel_inf  = &sp_exp;
    end else begin
      sel_exp  = dp_exp;
      sel_frac = dp_frac;
      sel_inf  = &dp_exp;
    end
  end

  i2f_classify u_cls (
    .sign    (src_sign),
    .is_zero (src_zero),
    .is_inf  (sel_inf),
    .cls     (cls_d)
  );

  // Next-state
  always_comb begin
    if (src_zero) begin
      res_d     = '0;
      inexact_d = 1'b0;
    end else begin
      res_d     = {src_sign, sel_exp, sel_frac};
      inexact_d = sgl_i ? sp_inx : dp_inx;
    end
    upd_d  = ~exact_path;
    cond_d = rec_i ? cls_d[CLS_W-1:1] : '0;
  end

  // Output register (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o      <= '0;
      inexact_o  <= 1'b0;
      flag_upd_o <= 1'b0;
      exc_sum_o  <= 1'b0;
      class_o    <= '0;
      cond_o     <= '0;
    end else begin
      res_o      <= res_d;
      inexact_o  <= inexact_d;
      flag_upd_o <= upd_d;
      exc_sum_o  <= inexact_d;
      class_o    <= cls_d;
      cond_o     <= cond_d;
    end
  end
endmodule

// File: rtl/i2f_convert_chk.sv
module i2f_convert_chk
  import i2f_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [XLEN-1:0]  opnd_i,
  input logic [1:0]       ityp_i,
  input logic             sgl_i,
  input logic             rec_i,
  input logic [XLEN-1:0]  res_o,
  input logic             inexact_o,
  input logic             flag_upd_o,
  input logic             exc_sum_o,
  input logic [CLS_W-1:0] class_o,
  input logic [CND_W-1:0] cond_o
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_zero_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ($past(opnd_i) == '0) |-> (res_o == '0) && (class_o == 5'b00010) && !inexact_o);

  assert_low_word_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(ityp_i[1]) && ($past(opnd_i[31:0]) == 32'd0) |-> (res_o == '0));

  assert_unsigned_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ($past(ityp_i) == 2'd1) |-> !res_o[XLEN-1]);

  assert_exact_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(ityp_i[1]) && !$past(sgl_i) |-> !flag_upd_o && !inexact_o && !exc_sum_o);

  assert_round_upd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ($past(ityp_i[1]) || $past(sgl_i)) |-> flag_upd_o);

  assert_sgl_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(sgl_i) |-> (res_o[PAD_W-1:0] == '0));

  assert_neg_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_o[XLEN-1] |-> (class_o == 5'b01000));

  assert_exc_on_round_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_sum_o |-> flag_upd_o);

  assert_no_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(rec_i) |-> (cond_o == '0));
endmodule

bind i2f_convert i2f_convert_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opnd_i     (opnd_i),
  .ityp_i     (ityp_i),
  .sgl_i      (sgl_i),
  .rec_i      (rec_i),
  .res_o      (res_o),
  .inexact_o  (inexact_o),
  .flag_upd_o (flag_upd_o),
  .exc_sum_o  (exc_sum_o),
  .class_o    (class_o),
  .cond_o     (cond_o)
);

// File: tb/tb_i2f_convert.sv
`timescale 1ns/1ps
module tb_i2f_convert;
  logic        clk;
  logic        rst_n;
  logic [63:0] opnd_i;
  logic [1:0]  ityp_i;
  logic        sgl_i;
  logic [1:0]  rmode_i;
  logic        rec_i;
  logic [63:0] res_o;
  logic        inexact_o;
  logic        flag_upd_o;
  logic        exc_sum_o;
  logic [4:0]  class_o;
  logic [3:0]  cond_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  i2f_convert dut (
    .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .ityp_i(ityp_i), .sgl_i(sgl_i),
    .rmode_i(rmode_i), .rec_i(rec_i), .res_o(res_o), .inexact_o(inexact_o),
    .flag_upd_o(flag_upd_o), .exc_sum_o(exc_sum_o), .class_o(class_o), .cond_o(cond_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0]  it;
    logic        sg;
    logic [1:0]  rm;
    logic        rc;
    logic [63:0] op;
    logic [63:0] ex;
    logic        xi;
    logic        xu;
    logic [4:0]  xc;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    // R2 signed word 1 -> 1.0, exact
    '{2'd0, 1'b0, 2'd0, 1'b1, 64'h0000_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b0, 1'b0, 5'b00100, 4'd2},
    // R2 upper word ignored, low word -1
    '{2'd0, 1'b0, 2'd1, 1'b0, 64'h1234_5678_FFFF_FFFF, 64'hBFF0_0000_0000_0000, 1'b0, 1'b0, 5'b01000, 4'd2},
    // R2 unsigned word 2^32-1
    '{2'd1, 1'b0, 2'd3, 1'b1, 64'hABCD_EF01_FFFF_FFFF, 64'h41EF_FFFF_FFE0_0000, 1'b0, 1'b0, 5'b00100, 4'd2},
    // R3 signed word minimum, exact
    '{2'd0, 1'b0, 2'd2, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'hC1E0_0000_0000_0000, 1'b0, 1'b0, 5'b01000, 4'd3},
    // R3 mode ignored on exact path
    '{2'd1, 1'b0, 2'd3, 1'b0, 64'h0000_0000_0000_0003, 64'h4008_0000_0000_0000, 1'b0, 1'b0, 5'b00100, 4'd3},
    // R1 signed 64 zero
    '{2'd2, 1'b0, 2'd0, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0, 1'b1, 5'b00010, 4'd1},
    // R9 signed 64 minimum exact
    '{2'd2, 1'b0, 2'd0, 1'b0, 64'h8000_0000_0000_0000, 64'hC3E0_0000_0000_0000, 1'b0, 1'b1, 5'b01000, 4'd9},
    // R9 carry into exponent
    '{2'd3, 1'b0, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h43F0_0000_0000_0000, 1'b1, 1'b1, 5'b00100, 4'd9},
    // R4 toward zero
    '{2'd3, 1'b0, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h43EF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 5'b00100, 4'd4},
    // R4 tie to even, stays
    '{2'd3, 1'b0, 2'd0, 1'b0, 64'h0020_0000_0000_0001, 64'h4340_0000_0000_0000, 1'b1, 1'b1, 5'b00100, 4'd4},
    // R4 toward plus infinity
    '{2'd3, 1'b0, 2'd2, 1'b0, 64'h0020_0000_0000_0001, 64'h4340_0000_0000_0001, 1'b1, 1'b1, 5'b00100, 4'd4},
    // R4 tie to even, goes up
    '{2'd2, 1'b0, 2'd0, 1'b0, 64'h0020_0000_0000_0003, 64'h4340_0000_0000_0002, 1'b1, 1'b1, 5'b00100, 4'd4},
    // R4 negative toward minus infinity
    '{2'd2, 1'b0, 2'd3, 1'b1, 64'hFFDF_FFFF_FFFF_FFFF, 64'hC340_0000_0000_0001, 1'b1, 1'b1, 5'b01000, 4'd4},
    // R4 negative toward plus infinity
    '{2'd2, 1'b0, 2'd2, 1'b0, 64'hFFDF_FFFF_FFFF_FFFF, 64'hC340_0000_0000_0000, 1'b1, 1'b1, 5'b01000, 4'd4},
    // R5 single exact
    '{2'd0, 1'b1, 2'd0, 1'b0, 64'h0000_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b0, 1'b1, 5'b00100, 4'd5},
    // R5 single tie to even
    '{2'd1, 1'b1, 2'd0, 1'b0, 64'h0000_0000_0100_0001, 64'h4170_0000_0000_0000, 1'b1, 1'b1, 5'b00100, 4'd5},
    // R5 single toward plus infinity
    '{2'd1, 1'b1, 2'd2, 1'b1, 64'h0000_0000_0100_0001, 64'h4170_0000_2000_0000, 1'b1, 1'b1, 5'b00100, 4'd5},
    // R9 single carry
    '{2'd1, 1'b1, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h41F0_0000_0000_0000, 1'b1, 1'b1, 5'b00100, 4'd9},
    // R5 single toward zero
    '{2'd1, 1'b1, 2'd1, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h41EF_FFFF_E000_0000, 1'b1, 1'b1, 5'b00100, 4'd5},
    // R5 single signed 64 -1
    '{2'd2, 1'b1, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hBFF0_0000_0000_0000, 1'b0, 1'b1, 5'b01000, 4'd5},
    // R9 single signed 64 minimum
    '{2'd2, 1'b1, 2'd3, 1'b0, 64'h8000_0000_0000_0000, 64'hC3E0_0000_0000_0000, 1'b0, 1'b1, 5'b01000, 4'd9},
    // R1 single unsigned 64 zero
    '{2'd3, 1'b1, 2'd0, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0, 1'b1, 5'b00010, 4'd1},
    // R2 upper word ignored, low word zero
    '{2'd1, 1'b0, 2'd0, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0000, 1'b0, 1'b0, 5'b00010, 4'd2}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic drive(input vec_t v);
    opnd_i  = v.op;
    ityp_i  = v.it;
    sgl_i   = v.sg;
    rmode_i = v.rm;
    rec_i   = v.rc;
  endtask

  task automatic chk_all_zero(input string tag);
    chk({tag, " res"}, res_o, 64'd0);
    chk({tag, " flags"}, {61'd0, inexact_o, flag_upd_o, exc_sum_o}, 64'd0);
    chk({tag, " class/cond"}, {55'd0, class_o, cond_o}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(VT[7]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state, inputs held non-zero
    chk_all_zero("R10 reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      @(negedge clk);
      chk($sformatf("R%0d result v%0d", VT[i].rq, i), res_o, VT[i].ex);
      chk($sformatf("R7 inexact v%0d", i), {62'd0, inexact_o, exc_sum_o}, {62'd0, VT[i].xi, VT[i].xi});
      chk($sformatf("%s flag update v%0d", (VT[i].it[1] | VT[i].sg) ? "R4" : "R3", i),
          {63'd0, flag_upd_o}, {63'd0, VT[i].xu});
      chk($sformatf("R6 class v%0d", i), {59'd0, class_o}, {59'd0, VT[i].xc});
      chk($sformatf("R8 cond v%0d", i), {60'd0, cond_o},
          {60'd0, (VT[i].rc ? VT[i].xc[4:1] : 4'd0)});
    end

    // R10 latency: new operands do not reach outputs before the next rising edge
    @(negedge clk);
    drive(VT[0]);
    @(negedge clk);
    drive(VT[6]);
    #1;
    chk("R10 hold before edge", res_o, 64'h3FF0_0000_0000_0000);
    @(negedge clk);
    chk("R10 after one edge", res_o, 64'hC3E0_0000_0000_0000);

    // R10 asynchronous reset clears outputs without a clock edge
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk_all_zero("R10 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset release", res_o, 64'hC3E0_0000_0000_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule